// File: doc/BRIEF.md
# Feedback-Clock Staggered Pulse Distributor

This block sits in the feedback-clock domain of a phase-locked loop. It turns each edge of the feedback clock into pulses on a bank of `NUM_OUT` outputs. The pulses are staggered in time across the bank. A modulo-`NUM_OUT` phase accumulator adds a programmable step on every edge. Each output stands for one accumulator value. An output fires for one cycle whenever the accumulator passes over that value. The phase comparator that follows uses these outputs as resets, one per group of partial detectors.

With a step of one, the bank is a rotating one-hot ring. A larger step makes the accumulator move several positions per edge, so several outputs fire together, and each output fires at an average rate of f_fb·step/`NUM_OUT`. When `NUM_OUT` is a multiple of the step, every output fires at fixed intervals. When it is not, the spacing varies from pulse to pulse but the long-run rate is still exact. A step of zero freezes the accumulator and silences the bank.

Top module: `fb_pulse_distributor`

## Requirements
- R1: A high `rst_i` at a clock edge clears the accumulator to 0 and `pulse_o` to all zeros, whatever the step is. The first edge after reset with step c drives exactly bits 1..c of `pulse_o` high.
- R2: At each edge outside reset, the accumulator value a advances to (a+c) mod NUM_OUT. At the same edge, `pulse_o` takes ones exactly at bit positions (a+1..a+c) mod NUM_OUT. These register outputs are visible until the next edge.
- R3: A window that runs past bit NUM_OUT-1 continues at bit 0. For example, a=30 with c=4 sets bits 31, 0, 1 and 2.
- R4: The number of ones in `pulse_o` after an edge equals the step that was sampled at that edge.
- R5: With step 1, `pulse_o` is one-hot and its set bit moves up by one position per edge, wrapping from NUM_OUT-1 to 0.
- R6: Step 0 gives an all-zero `pulse_o` and keeps the accumulator value. A later nonzero step resumes from the held value.
- R7: With a step that divides NUM_OUT, each output fires exactly once every NUM_OUT/step edges.
- R8: With any constant step c, over any NUM_OUT consecutive edges each output fires exactly c times. This holds even when NUM_OUT is not a multiple of c.
- R9: A new step value takes effect at the next edge. The accumulator contents are not disturbed by the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Feedback clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | $clog2(NUM_OUT) | Accumulator step c; a value at or above NUM_OUT is taken modulo NUM_OUT |
| pulse_o | output | NUM_OUT | Staggered pulse outputs, one register bit per accumulator value |

## Verification
The bench goes after several corner cases, and each has a typical wrong-design symptom:
- **Window wrap at the top of the range.** A design that compares plain magnitudes drops bits 0..k or raises a wrong band of bits when a + c exceeds NUM_OUT-1.
- **Step 0.** A design that advances anyway, or decodes an empty window as one bit, fires stray pulses. It may also resume from the wrong phase.
- **Step changes mid-run.** A design that reloads or clears the accumulator on a change shows a phase jump against the model.
- **Long-run rate with non-dividing steps.** Per-output counts over a full lap expose off-by-one window ends, which would give c-1 or c+1 pulses. Fixed-interval checks for dividing steps expose irregular spacing.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Modular add for operands already below q.
  function automatic int unsigned pd_wrap_add(int unsigned a, int unsigned b, int unsigned q);
    int unsigned s;
    s = a + b;
    return (s >= q) ? s - q : s;
  endfunction

  // True when position j lies in the half-open arc (a, a+c] modulo q.
  function automatic logic pd_in_window(int unsigned j, int unsigned a, int unsigned c,
                                        int unsigned q);
    int unsigned d;
    d = pd_wrap_add(j, q - a, q);
    return (d != 0) && (d <= c);
  endfunction

endpackage

// File: rtl/pd_step_reduce.sv
module pd_step_reduce #(
  parameter int unsigned NUM_OUT = 32,
  parameter int unsigned AW      = 5
) (
  input  logic [AW-1:0] step_raw,
  output logic [AW-1:0] step_red
);
  // step_raw < 2^AW < 2*NUM_OUT, so one subtraction is enough.
  always_comb begin
    if (32'(step_raw) >= NUM_OUT) step_red = AW'(32'(step_raw) - NUM_OUT);
    else                          step_red = step_raw;
  end
endmodule

// File: rtl/pd_phase_acc.sv
module pd_phase_acc
  import pd_pkg::*;
#(
  parameter int unsigned NUM_OUT = 32,
  parameter int unsigned AW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] step_red,
  output logic [AW-1:0] acc_q
);
  logic [AW-1:0] acc_nxt;

  always_comb acc_nxt = AW'(pd_wrap_add(32'(acc_q), 32'(step_red), NUM_OUT));

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_nxt;
  end

  // R6: a zero step leaves the phase where it was
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (step_red == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pd_window_decode.sv
module pd_window_decode
  import pd_pkg::*;
#(
  parameter int unsigned NUM_OUT = 32,
  parameter int unsigned AW      = 5
) (
  input  logic [AW-1:0]      acc_q,
  input  logic [AW-1:0]      step_red,
  output logic [NUM_OUT-1:0] hit
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pos
    assign hit[g] = pd_in_window(g, 32'(acc_q), 32'(step_red), NUM_OUT);
  end
endmodule

// File: rtl/fb_pulse_distributor.sv
module fb_pulse_distributor #(
  parameter int unsigned NUM_OUT = 32,
  localparam int unsigned AW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [AW-1:0]      step_i,
  output logic [NUM_OUT-1:0] pulse_o
);
  logic [AW-1:0]      step_red;
  logic [AW-1:0]      acc_q;
  logic [NUM_OUT-1:0] hit;
  logic [NUM_OUT-1:0] pulse_q;

  pd_step_reduce #(.NUM_OUT(NUM_OUT), .AW(AW)) u_reduce (
    .step_raw(step_i), .step_red(step_red));

  pd_phase_acc #(.NUM_OUT(NUM_OUT), .AW(AW)) u_acc (
    .clk(clk_i), .rst(rst_i), .step_red(step_red), .acc_q(acc_q));

  pd_window_decode #(.NUM_OUT(NUM_OUT), .AW(AW)) u_dec (
    .acc_q(acc_q), .step_red(step_red), .hit(hit));

  always_ff @(posedge clk_i) begin
    if (rst_i) pulse_q <= '0;
    else       pulse_q <= hit;
  end

  assign pulse_o = pulse_q;

  // R1: the cycle after reset shows zero phase and a silent bank
  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (pulse_q == '0 && acc_q == '0));

  // R2: the landing value of the accumulator is always inside the window
  p_land_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_red != '0) |=> pulse_q[acc_q]);

  // R4: pulse count follows the step sampled at the edge
  p_count_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ($countones(pulse_q) == int'($past(step_red))));
endmodule

// File: tb/test_fb_pulse_distributor.sv
module test_fb_pulse_distributor;
  localparam int Q  = 32;
  localparam int AW = $clog2(Q);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] step = '0;
  logic [Q-1:0]  pulse;

  always #10 clk = ~clk;

  fb_pulse_distributor #(.NUM_OUT(Q)) i_fb_pulse_distributor (
    .clk_i(clk), .rst_i(rst), .step_i(step), .pulse_o(pulse));

  int checks = 0;
  int errors = 0;
  int m_acc  = 0;
  int cyc    = 0;
  bit done   = 0;
  logic [Q-1:0] m_exp = '0;
  logic [Q-1:0] seen;
  int last_seen [Q];
  int fire_cnt  [Q];

  function automatic logic [Q-1:0] exp_window(int a, int c);
    logic [Q-1:0] w = '0;
    for (int k = 1; k <= c; k++) w[(a + k) % Q] = 1'b1;
    return w;
  endfunction

  function automatic int pop(logic [Q-1:0] v);
    int n = 0;
    for (int i = 0; i < Q; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare at next fall.
  task automatic tick(int c, bit r, string tag);
    rst  = r;
    step = AW'(c);
    if (r) begin
      m_exp = '0;
      m_acc = 0;
    end else begin
      m_exp = exp_window(m_acc, c);
      m_acc = (m_acc + c) % Q;
    end
    @(negedge clk);
    cyc++;
    seen = pulse;
    check(seen == m_exp, tag, "pulse", longint'(seen), longint'(m_exp));
    if (!r) check(pop(seen) == c, "R4", "count", pop(seen), c);
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);

    // R1: reset clears, even with a nonzero step present
    tick(0, 1, "R1");
    tick(7, 1, "R1");
    tick(7, 1, "R1");
    tick(3, 0, "R1");
    check(seen == 32'h0000_000E, "R1", "first window after reset", longint'(seen), 64'hE);

    // R5: ring behaviour with wrap
    for (int i = 0; i < 40; i++) begin
      tick(1, 0, "R5");
      check(pop(seen) == 1, "R5", "one-hot", pop(seen), 1);
    end

    // R6: zero step holds and silences, then resumes from the held phase
    for (int i = 0; i < 5; i++) tick(0, 0, "R6");
    tick(1, 0, "R6");

    // R7: step dividing the bank size gives a fixed interval
    for (int j = 0; j < Q; j++) last_seen[j] = -1;
    for (int i = 0; i < 40; i++) begin
      tick(8, 0, "R7");
      for (int j = 0; j < Q; j++) if (seen[j]) begin
        if (last_seen[j] >= 0)
          check(cyc - last_seen[j] == Q / 8, "R7", "interval", cyc - last_seen[j], Q / 8);
        last_seen[j] = cyc;
      end
    end

    // R8: non-dividing steps, exact count per lap
    foreach (fire_cnt[j]) fire_cnt[j] = 0;
    for (int i = 0; i < Q; i++) begin
      tick(5, 0, "R8");
      for (int j = 0; j < Q; j++) fire_cnt[j] += int'(seen[j]);
    end
    for (int j = 0; j < Q; j++) check(fire_cnt[j] == 5, "R8", "count c=5", fire_cnt[j], 5);
    foreach (fire_cnt[j]) fire_cnt[j] = 0;
    for (int i = 0; i < Q; i++) begin
      tick(3, 0, "R8");
      for (int j = 0; j < Q; j++) fire_cnt[j] += int'(seen[j]);
    end
    for (int j = 0; j < Q; j++) check(fire_cnt[j] == 3, "R8", "count c=3", fire_cnt[j], 3);

    // R3: explicit wrap from phase 30 with step 4
    tick(0, 1, "R1");
    tick(30, 0, "R3");
    tick(4, 0, "R3");
    check(seen == 32'h8000_0007, "R3", "wrap window", longint'(seen), 64'h8000_0007);
    for (int i = 0; i < 6; i++) tick(31, 0, "R3");

    // R9: step changes mid-run keep the phase
    tick(2, 0, "R9");
    tick(7, 0, "R9");
    tick(1, 0, "R9");
    tick(0, 0, "R9");
    tick(13, 0, "R9");
    tick(6, 0, "R9");

    // R1: reset in mid-run
    tick(9, 1, "R1");
    tick(4, 0, "R1");
    check(seen == 32'h0000_001E, "R1", "window after mid-run reset", longint'(seen), 64'h1E);

    // R2: random steps with occasional reset
    for (int i = 0; i < 3000; i++) begin
      int c;
      bit r;
      c = int'($urandom_range(0, Q - 1));
      r = ($urandom_range(0, 99) < 2);
      tick(c, r, r ? "R1" : "R2");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule